// File: doc/BRIEF.md
# Two-Wire Bus Write-Only Master

This block is the master side of a two-wire serial bus and handles write transfers only. Software sets a 7-bit target address, a clock exponent and separate high-phase and low-phase divisors, and an interrupt mask. It then writes a byte into the holding register. If the block is idle and master operation is enabled, that write starts a transfer. The block sends a start condition, then the address followed by a zero direction bit, then data bytes. After each byte it checks the acknowledge bit.

Three status flags report progress. The ready flag shows that the holding register may be refilled. The complete flag shows that the bus is idle after a stop. The not-acknowledged flag shows that the target refused a byte. Software keeps a transfer going by refilling the holding register before each acknowledge. When no byte is waiting one bit-time after an acknowledge, the block issues a stop. Both bus lines are open-drain: each has an output enable that pulls the line low. The data line is read back through an input pin.

Top module: `i2cw_master`

## Requirements
- R1: After reset both output enables are 0, ready is 1, complete is 1, not-acknowledged is 0 and irq is 0.
- R2: A holding write starts a transfer only when `cfg_master_en` and `cfg_slave_off` are both 1 and the block is idle. Any other idle holding write is ignored: no line is driven and ready stays 1.
- R3: After a starting write, both lines stay released for one high period. Then SDA is pulled low for one high period with SCL released, and then SCL is pulled low.
- R4: The low period is `cfg_low_div * 2^cfg_clk_exp + 4` clocks and the high period is `cfg_high_div * 2^cfg_clk_exp + 4` clocks. The first byte is the address, MSB first, followed by a 0. Each bit holds SCL low for one low period and then releases it for one high period. SDA is constant across the whole bit.
- R5: The ninth pulse of every byte releases SDA. SDA is sampled in the last clock of that pulse's high phase, and a low level means acknowledge.
- R6: Any holding write clears ready. On an acknowledge with a byte waiting, that byte is loaded, ready becomes 1, and the byte's first bit begins right away.
- R7: On an acknowledge with nothing waiting, SCL and SDA are held low for one low period plus one high period. A byte written during that window is sent next. Otherwise SCL is released for one high period, SDA is then released, and after another high period the block is idle with complete = 1.
- R8: On a refused byte, not-acknowledged becomes 1 and the block performs a stop. The stop holds both lines low for a low period, releases SCL for a high period, then releases SDA for a high period. The block then goes idle with complete = 1, and a waiting byte stays waiting (ready unchanged).
- R9: A pulse on `sts_rd` clears not-acknowledged. If the flag is being set in the same cycle, it stays set.
- R10: irq is the OR of the masked flags. Mask bit 0 selects complete, bit 1 selects ready and bit 2 selects not-acknowledged.
- R11: Complete is cleared by the write that starts a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_master_en | input | 1 | Master operation enable |
| cfg_slave_off | input | 1 | Target operation disabled; needed for master operation |
| cfg_dev_addr | input | 7 | Target address |
| cfg_clk_exp | input | EXP_W | Exponent prescale shared by both phases |
| cfg_high_div | input | DIV_W | SCL high-phase divisor |
| cfg_low_div | input | DIV_W | SCL low-phase divisor |
| cfg_irq_mask | input | 3 | Interrupt mask {nack, ready, complete} |
| thr_wr | input | 1 | Holding register write strobe |
| thr_data | input | 8 | Holding register write data |
| sts_rd | input | 1 | Status read strobe |
| sts_txrdy | output | 1 | Holding register may be written |
| sts_txcomp | output | 1 | Bus idle after stop |
| sts_nack | output | 1 | Target refused a byte |
| irq | output | 1 | Interrupt request |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| sda_in | input | 1 | SDA line level |

## Verification
Two pairs of events can fall in the same clock. The first pair is a status read arriving in the exact cycle that the refused-acknowledge sample sets the not-acknowledged flag. The bench provokes it by marking that final sample cycle in its waveform model and pulsing `sts_rd` there. It then expects the flag to stay set, and to clear only on a later read. The second pair is a holding write landing during the byte before an acknowledge, so that the load and the ready update meet in the ack cycle. Here the bench expects no gap between bytes, and expects ready to fall at the write and rise again after the acknowledge.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_START,
        ST_LOW,
        ST_HIGH,
        ST_GAP,
        ST_STOP_LOW,
        ST_STOP_HIGH,
        ST_STOP_SU
    } state_e;

    localparam int BYTE_W = 8;
    localparam int BITCNT_W = 4;
    localparam int ACK_SLOT = 8;
    localparam int FLAG_N = 3;
endpackage

// File: rtl/i2cw_period.sv
module i2cw_period #(
    parameter int DIV_W = 8,
    parameter int EXP_W = 3,
    parameter int CNT_W = 17
) (
    input  logic [DIV_W-1:0] div,
    input  logic [EXP_W-1:0] expo,
    output logic [CNT_W-1:0] period
);
    localparam logic [CNT_W-1:0] FIXED_ADD = CNT_W'(4);

    assign period = (CNT_W'(div) << expo) + FIXED_ADD;
endmodule

// File: rtl/i2cw_irq.sv
module i2cw_irq #(
    parameter int N = 3
) (
    input  logic [N-1:0] flags,
    input  logic [N-1:0] mask,
    output logic         irq
);
    logic [N-1:0] hit;

    generate
        for (genvar i = 0; i < N; i++) begin : g_hit
            assign hit[i] = flags[i] & mask[i];
        end
    endgenerate

    assign irq = |hit;
endmodule

// File: rtl/i2cw_master.sv
module i2cw_master
    import i2cw_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int EXP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_master_en,
    input  logic             cfg_slave_off,
    input  logic [6:0]       cfg_dev_addr,
    input  logic [EXP_W-1:0] cfg_clk_exp,
    input  logic [DIV_W-1:0] cfg_high_div,
    input  logic [DIV_W-1:0] cfg_low_div,
    input  logic [2:0]       cfg_irq_mask,
    input  logic             thr_wr,
    input  logic [7:0]       thr_data,
    input  logic             sts_rd,
    output logic             sts_txrdy,
    output logic             sts_txcomp,
    output logic             sts_nack,
    output logic             irq,
    output logic             scl_oe,
    output logic             sda_oe,
    input  logic             sda_in
);
    localparam int CNT_W = DIV_W + (1 << EXP_W) + 1;

    typedef struct packed {
        state_e              state;
        logic [CNT_W-1:0]    cnt;
        logic [BITCNT_W-1:0] bitcnt;
        logic [BYTE_W-1:0]   shreg;
        logic [BYTE_W-1:0]   hold;
        logic                txrdy;
        logic                txcomp;
        logic                nack;
        logic                scl_oe;
        logic                sda_oe;
    } regs_t;

    localparam regs_t RST_VAL = '{
        state:  ST_IDLE,
        cnt:    '0,
        bitcnt: '0,
        shreg:  '0,
        hold:   '0,
        txrdy:  1'b1,
        txcomp: 1'b1,
        nack:   1'b0,
        scl_oe: 1'b0,
        sda_oe: 1'b0
    };

    regs_t q, d;
    logic [CNT_W-1:0] t_low, t_high;
    logic enabled, tick;

    i2cw_period #(.DIV_W(DIV_W), .EXP_W(EXP_W), .CNT_W(CNT_W)) u_low_per (
        .div(cfg_low_div), .expo(cfg_clk_exp), .period(t_low)
    );

    i2cw_period #(.DIV_W(DIV_W), .EXP_W(EXP_W), .CNT_W(CNT_W)) u_high_per (
        .div(cfg_high_div), .expo(cfg_clk_exp), .period(t_high)
    );

    assign enabled = cfg_master_en & cfg_slave_off;

    always_comb begin
        d    = q;
        tick = (q.cnt == '0);

        // holding register update, shared by idle and busy
        if (thr_wr && (q.state != ST_IDLE || enabled)) begin
            d.hold  = thr_data;
            d.txrdy = 1'b0;
        end
        if (sts_rd) begin
            d.nack = 1'b0;
        end

        if (q.state == ST_IDLE) begin
            if (thr_wr && enabled) begin
                d.state  = ST_SETUP;
                d.cnt    = t_high - 1'b1;
                d.txcomp = 1'b0;
            end
        end else if (!tick) begin
            d.cnt = q.cnt - 1'b1;
        end else begin
            case (q.state)
                ST_SETUP: begin
                    d.state = ST_START;
                    d.cnt   = t_high - 1'b1;
                end
                ST_START: begin
                    d.state  = ST_LOW;
                    d.cnt    = t_low - 1'b1;
                    d.shreg  = {cfg_dev_addr, 1'b0};
                    d.bitcnt = '0;
                end
                ST_LOW: begin
                    d.state = ST_HIGH;
                    d.cnt   = t_high - 1'b1;
                end
                ST_HIGH: begin
                    if (q.bitcnt != BITCNT_W'(ACK_SLOT)) begin
                        d.bitcnt = q.bitcnt + 1'b1;
                        d.shreg  = {q.shreg[BYTE_W-2:0], 1'b0};
                        d.state  = ST_LOW;
                        d.cnt    = t_low - 1'b1;
                    end else if (sda_in) begin
                        d.nack  = 1'b1;
                        d.state = ST_STOP_LOW;
                        d.cnt   = t_low - 1'b1;
                    end else if (!d.txrdy) begin
                        d.shreg  = d.hold;
                        d.txrdy  = 1'b1;
                        d.bitcnt = '0;
                        d.state  = ST_LOW;
                        d.cnt    = t_low - 1'b1;
                    end else begin
                        d.state = ST_GAP;
                        d.cnt   = t_low + t_high - 1'b1;
                    end
                end
                ST_GAP: begin
                    if (!d.txrdy) begin
                        d.shreg  = d.hold;
                        d.txrdy  = 1'b1;
                        d.bitcnt = '0;
                        d.state  = ST_LOW;
                        d.cnt    = t_low - 1'b1;
                    end else begin
                        d.state = ST_STOP_HIGH;
                        d.cnt   = t_high - 1'b1;
                    end
                end
                ST_STOP_LOW: begin
                    d.state = ST_STOP_HIGH;
                    d.cnt   = t_high - 1'b1;
                end
                ST_STOP_HIGH: begin
                    d.state = ST_STOP_SU;
                    d.cnt   = t_high - 1'b1;
                end
                ST_STOP_SU: begin
                    d.state  = ST_IDLE;
                    d.txcomp = 1'b1;
                end
                default: begin
                    d.state = ST_IDLE;
                end
            endcase
        end

        // line drivers follow the next state so they are registered
        d.scl_oe = (d.state == ST_LOW) || (d.state == ST_GAP) || (d.state == ST_STOP_LOW);
        case (d.state)
            ST_START, ST_GAP, ST_STOP_LOW, ST_STOP_HIGH: d.sda_oe = 1'b1;
            ST_LOW, ST_HIGH: d.sda_oe = (d.bitcnt != BITCNT_W'(ACK_SLOT)) && !d.shreg[BYTE_W-1];
            default: d.sda_oe = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else begin
            q <= d;
        end
    end

    i2cw_irq #(.N(FLAG_N)) u_irq (
        .flags({q.nack, q.txrdy, q.txcomp}),
        .mask (cfg_irq_mask),
        .irq  (irq)
    );

    assign sts_txrdy  = q.txrdy;
    assign sts_txcomp = q.txcomp;
    assign sts_nack   = q.nack;
    assign scl_oe     = q.scl_oe;
    assign sda_oe     = q.sda_oe;
endmodule

// File: rtl/i2cw_chk.sv
module i2cw_chk
    import i2cw_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_master_en,
    input logic       cfg_slave_off,
    input logic [2:0] cfg_irq_mask,
    input logic       thr_wr,
    input logic       sts_rd,
    input logic       sts_txrdy,
    input logic       sts_txcomp,
    input logic       sts_nack,
    input logic       irq,
    input logic       scl_oe,
    input logic       sda_oe,
    input state_e     st
);
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_txcomp && !(thr_wr && cfg_master_en && cfg_slave_off))
            |=> (sts_txcomp && !scl_oe && !sda_oe));

    // R4
    sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HIGH && $past(st) == ST_HIGH) |-> $stable(sda_oe));

    // R6
    txrdy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sts_txrdy) |-> $past(thr_wr));

    // R7
    stop_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_txcomp) |-> (!scl_oe && !sda_oe && $past(!scl_oe)));

    // R8
    nack_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_nack) |-> ($rose(scl_oe) && sda_oe));

    // R9
    nack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sts_nack) |-> $past(sts_rd));

    // R10
    irq_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_irq_mask[2] && sts_nack) |-> irq);

    // R11
    txcomp_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sts_txcomp) |-> $past(thr_wr));
endmodule

bind i2cw_master i2cw_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_master_en(cfg_master_en),
    .cfg_slave_off(cfg_slave_off),
    .cfg_irq_mask (cfg_irq_mask),
    .thr_wr       (thr_wr),
    .sts_rd       (sts_rd),
    .sts_txrdy    (sts_txrdy),
    .sts_txcomp   (sts_txcomp),
    .sts_nack     (sts_nack),
    .irq          (irq),
    .scl_oe       (scl_oe),
    .sda_oe       (sda_oe),
    .st           (q.state)
);

// File: tb/tb_i2cw_master.sv
`timescale 1ns/1ps
module tb_i2cw_master;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_master_en = 1'b1;
    logic       cfg_slave_off = 1'b1;
    logic [6:0] cfg_dev_addr = 7'h5A;
    logic [2:0] cfg_clk_exp = 3'd1;
    logic [7:0] cfg_high_div = 8'd1;
    logic [7:0] cfg_low_div = 8'd2;
    logic [2:0] cfg_irq_mask = 3'b000;
    logic       thr_wr = 1'b0;
    logic [7:0] thr_data = 8'h00;
    logic       sts_rd = 1'b0;
    logic       sts_txrdy, sts_txcomp, sts_nack, irq, scl_oe, sda_oe;
    logic       sda_in;
    logic       slave_pull = 1'b0;

    assign sda_in = !sda_oe && !slave_pull;

    i2cw_master dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_master_en(cfg_master_en), .cfg_slave_off(cfg_slave_off),
        .cfg_dev_addr(cfg_dev_addr), .cfg_clk_exp(cfg_clk_exp),
        .cfg_high_div(cfg_high_div), .cfg_low_div(cfg_low_div),
        .cfg_irq_mask(cfg_irq_mask),
        .thr_wr(thr_wr), .thr_data(thr_data), .sts_rd(sts_rd),
        .sts_txrdy(sts_txrdy), .sts_txcomp(sts_txcomp), .sts_nack(sts_nack),
        .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit scl; bit sda; bit pull; bit txrdy; bit nack;
        bit wr; bit rd; logic [7:0] wdata; int req;
    } ent_t;

    ent_t       exp_q[$];
    logic [7:0] data_q[$];
    bit         ack_q[$];
    int         tl, th;
    bit         m_txrdy, m_nack;

    task automatic check(input bit ok, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, expv);
        end
    endtask

    task automatic set_periods();
        tl = cfg_low_div * (1 << cfg_clk_exp) + 4;
        th = cfg_high_div * (1 << cfg_clk_exp) + 4;
    endtask

    task automatic push(input int n, input bit scl, input bit sda, input bit pull, input int req);
        for (int i = 0; i < n; i++) begin
            ent_t e;
            e.scl = scl; e.sda = sda; e.pull = pull;
            e.txrdy = m_txrdy; e.nack = m_nack;
            e.wr = 0; e.rd = 0; e.wdata = 8'h00; e.req = req;
            exp_q.push_back(e);
        end
    endtask

    // behavioural bus model: one entry per clock after the starting write
    task automatic build(input logic [6:0] addr, input bit rd_on_nack);
        int nd;
        nd = data_q.size();
        m_txrdy = 0; m_nack = 0;
        exp_q.delete();
        push(th, 0, 0, 0, 3); // R3 setup
        push(th, 0, 1, 0, 3); // R3 start
        for (int k = 0; k <= nd; k++) begin
            logic [7:0] b;
            b = (k == 0) ? {addr, 1'b0} : data_q[k-1];
            for (int i = 7; i >= 0; i--) begin
                if (k >= 1 && k < nd && i == 5) begin
                    exp_q[exp_q.size()-1].wr = 1; // R6 refill during byte
                    exp_q[exp_q.size()-1].wdata = data_q[k];
                    m_txrdy = 0;
                end
                push(tl, 1, !b[i], 0, 4); // R4
                push(th, 0, !b[i], 0, 4);
            end
            push(tl, 1, 0, ack_q[k], 5); // R5
            push(th, 0, 0, ack_q[k], 5);
            if (!ack_q[k]) begin
                if (rd_on_nack) exp_q[exp_q.size()-1].rd = 1; // R9 collision
                m_nack = 1;
                push(tl, 1, 1, 0, 8); // R8
                push(th, 0, 1, 0, 8);
                push(th, 0, 0, 0, 8);
                break;
            end
            if (k < nd) m_txrdy = 1; // R6
            else begin
                push(tl + th, 1, 1, 0, 7); // R7
                push(th, 0, 1, 0, 7);
                push(th, 0, 0, 0, 7);
            end
        end
    endtask

    task automatic run_transfer(input logic [7:0] first);
        @(negedge clk);
        thr_wr = 1; thr_data = first;
        while (exp_q.size() > 0) begin
            ent_t e;
            logic [5:0] act, expv;
            logic ei;
            @(negedge clk);
            thr_wr = 0; sts_rd = 0;
            e = exp_q.pop_front();
            slave_pull = e.pull;
            ei = (cfg_irq_mask[1] & e.txrdy) | (cfg_irq_mask[2] & e.nack);
            act  = {scl_oe, sda_oe, sts_txrdy, sts_txcomp, sts_nack, irq};
            expv = {e.scl, e.sda, e.txrdy, 1'b0, e.nack, ei};
            check(act == expv, $sformatf("R%0d bus/status {scl,sda,rdy,comp,nack,irq}", e.req), act, expv);
            if (e.wr) begin thr_wr = 1; thr_data = e.wdata; end
            if (e.rd) sts_rd = 1;
        end
        @(negedge clk);
        thr_wr = 0; sts_rd = 0; slave_pull = 0;
        begin
            logic [5:0] act, expv;
            logic ei;
            ei = cfg_irq_mask[0] | (cfg_irq_mask[1] & m_txrdy) | (cfg_irq_mask[2] & m_nack);
            act  = {scl_oe, sda_oe, sts_txrdy, sts_txcomp, sts_nack, irq};
            expv = {1'b0, 1'b0, m_txrdy, 1'b1, m_nack, ei};
            check(act == expv, "R7 idle after stop", act, expv);
        end
    endtask

    task automatic clear_nack();
        @(negedge clk); sts_rd = 1;
        @(negedge clk); sts_rd = 0;
        check(sts_nack == 0, "R9 nack cleared by read", sts_nack, 0);
        check(irq == cfg_irq_mask[0], "R10 irq after clear", irq, cfg_irq_mask[0]);
    endtask

    task automatic ignored_write(input string what);
        bit quiet;
        quiet = 1;
        @(negedge clk); thr_wr = 1; thr_data = 8'h3C;
        @(negedge clk); thr_wr = 0;
        for (int i = 0; i < 30; i++) begin
            if (scl_oe || sda_oe || !sts_txcomp) quiet = 0;
            @(negedge clk);
        end
        check(quiet, {"R2 no bus activity ", what}, quiet, 1);
        check(sts_txrdy == 1, {"R2 ready unchanged ", what}, sts_txrdy, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check({scl_oe, sda_oe, sts_txrdy, sts_txcomp, sts_nack, irq} == 6'b001100,
              "R1 reset outputs", {scl_oe, sda_oe, sts_txrdy, sts_txcomp, sts_nack, irq}, 6'b001100);
        rst_n = 1;
        @(negedge clk);
        check({scl_oe, sda_oe, sts_txrdy, sts_txcomp, sts_nack} == 5'b00110,
              "R1 after reset release", {scl_oe, sda_oe, sts_txrdy, sts_txcomp, sts_nack}, 5'b00110);

        // R2 disabled combinations
        cfg_slave_off = 0;
        ignored_write("slave not off");
        cfg_slave_off = 1; cfg_master_en = 0;
        ignored_write("master off");
        cfg_master_en = 1;

        // single byte, ready interrupt (R3 R4 R5 R6 R7 R10 R11)
        cfg_irq_mask = 3'b010;
        set_periods();
        data_q = '{8'hC3};
        ack_q = '{1, 1};
        build(7'h5A, 0);
        run_transfer(8'hC3);

        // three bytes at the smallest divisors, refills mid-byte (R4 R6)
        cfg_clk_exp = 0; cfg_high_div = 0; cfg_low_div = 0;
        cfg_irq_mask = 3'b100;
        cfg_dev_addr = 7'h7F;
        set_periods();
        data_q = '{8'hA5, 8'h00, 8'hFF};
        ack_q = '{1, 1, 1, 1};
        build(7'h7F, 0);
        run_transfer(8'hA5);

        // refused address, waiting byte kept (R8 R10)
        cfg_clk_exp = 1; cfg_high_div = 1; cfg_low_div = 2;
        cfg_dev_addr = 7'h12;
        set_periods();
        data_q = '{8'h66};
        ack_q = '{0, 0};
        build(7'h12, 0);
        run_transfer(8'h66);
        check(irq == 1, "R10 irq on nack", irq, 1);
        clear_nack();
        check(sts_txrdy == 0, "R8 waiting byte still pending", sts_txrdy, 0);

        // refused second data byte, read collides with the set (R9)
        cfg_clk_exp = 2; cfg_high_div = 3; cfg_low_div = 1;
        cfg_irq_mask = 3'b101;
        cfg_dev_addr = 7'h29;
        set_periods();
        data_q = '{8'h11, 8'h22};
        ack_q = '{1, 1, 0};
        build(7'h29, 1);
        run_transfer(8'h11);
        check(sts_nack == 1, "R9 set wins over same-cycle read", sts_nack, 1);
        clear_nack();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule